// File: doc/BRIEF.md
# Single to Half Precision Converter

This block narrows a 32-bit IEEE binary32 operand to a 16-bit binary16 value. The 16-bit result is placed into one half of a caller-supplied 32-bit destination word, and the other half of that word is kept unchanged. A per-operation control set selects the behaviour:

- one of four rounding directions;
- substitution of a canonical quiet NaN;
- an alternative 16-bit format that has no infinities and no NaNs and uses the top exponent code for ordinary finite values;
- an underflow-trap-enable bit, which changes only when the underflow flag is raised.

The conversion is one cycle long. Inputs presented with `in_vld` high are captured at the next rising edge. The merged word appears with `out_vld` one cycle after `in_vld`, together with single-cycle pulses on four exception flags (invalid, overflow, underflow, inexact). Collecting these flags into a sticky status register is the job of the surrounding pipeline.

Top module: `f2h_convert`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by one clock. `result` updates only on a cycle after `in_vld` was high and otherwise holds. All flags are 0 on any cycle where `out_vld` is 0. Synchronous reset clears `out_vld`, `result` and the flags.
- R2: When `sel_hi`=1 the converted value replaces `result[31:16]` and `result[15:0]` equals `dst[15:0]`. When `sel_hi`=0 it replaces `result[15:0]` and `result[31:16]` equals `dst[31:16]`. The 16-bit value is {sign[15], exponent[14:10], mantissa[9:0]}.
- R3: In IEEE mode (`alt_fmt`=0) with `dflt_nan`=0, a NaN input gives sign, exponent 0x1F, and mantissa `src[22:13]` with bit 9 forced to 1. Invalid is raised exactly when `src[22]` is 0 (a signalling NaN).
- R4: In IEEE mode with `dflt_nan`=1, every NaN gives 0x7E00. Invalid is raised exactly when `src[22]` is 0.
- R5: With `alt_fmt`=1 (which overrides `dflt_nan`), a NaN gives a signed zero and an infinity gives {sign, 0x1F, 0x3FF}; both raise invalid only. In IEEE mode an infinity gives {sign, 0x1F, 0} with no flags.
- R6: A zero input of either sign gives the same-signed 16-bit zero with no flags, even with `uf_trap_en`=1.
- R7: A finite input whose rebiased exponent (input exponent minus 112) lies in 1..30 and whose low 13 mantissa bits are zero converts exactly, with no flags.
- R8: Rounding uses `rmode` 00 = nearest-even, 01 = toward +infinity, 10 = toward -infinity, 11 = toward zero. Any nonzero discarded bit raises inexact.
- R9: A rounding increment that carries out of the mantissa clears it and adds one to the exponent, including the step from the largest subnormal to the smallest normal (0x0400).
- R10: A rebiased exponent at or below 0 yields a subnormal by right shift with the implicit one inserted; binary32 subnormal inputs take the same path. Underflow is raised when the pre-rounding exponent is 0 and either the result is inexact or `uf_trap_en`=1.
- R11: In IEEE mode a rounded exponent of 31 or more raises overflow and inexact. It gives infinity for nearest, for +infinity rounding with positive sign, and for -infinity rounding with negative sign. Otherwise it gives {sign, 0x1E, 0x3FF}.
- R12: In the alternative format, a rounded exponent of 31 is a normal value. An exponent of 32 or more gives {sign, 0x1F, 0x3FF} and raises invalid, with overflow and inexact clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation request |
| src | input | 32 | Binary32 operand |
| dst | input | 32 | Destination word to merge into |
| sel_hi | input | 1 | 1: write upper half, 0: write lower half |
| rmode | input | 2 | Rounding direction (see R8) |
| dflt_nan | input | 1 | Canonical NaN substitution enable |
| alt_fmt | input | 1 | Alternative 16-bit format enable |
| uf_trap_en | input | 1 | Underflow trap enable (affects flag only) |
| out_vld | output | 1 | Result valid |
| result | output | 32 | Merged destination word |
| flg_invalid | output | 1 | Invalid operation pulse |
| flg_overflow | output | 1 | Overflow pulse |
| flg_underflow | output | 1 | Underflow pulse |
| flg_inexact | output | 1 | Inexact pulse |

## Verification
The only state is the output register, so any internal fault shows up on `result` or a flag one cycle after the faulty operation and affects no later operation. A wrong shift amount or a lost sticky bit surfaces as an off-by-one mantissa or a missing inexact pulse on subnormal results. A wrong overflow threshold is exposed by the exponent-31 inputs, which must saturate in IEEE mode and stay finite in the alternative format. Halfword steering faults show as corrupted bits in the half of `dst` that should have been preserved.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
    localparam int SP_EW   = 8;
    localparam int SP_MW   = 23;
    localparam int HP_EW   = 5;
    localparam int HP_MW   = 10;
    localparam int HP_W    = 1 + HP_EW + HP_MW;
    localparam int SP_W    = 1 + SP_EW + SP_MW;
    localparam int DROP    = SP_MW - HP_MW;
    localparam int REBIAS  = (1 << (SP_EW - 1)) - (1 << (HP_EW - 1));
    localparam int SIG_W   = SP_MW + 1;
    localparam int PAD     = SIG_W + 2;
    localparam int EXP_W   = SP_EW + 2;
    localparam int HP_EMAX = (1 << HP_EW) - 1;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_POS  = 2'b01,
        RND_NEG  = 2'b10,
        RND_ZERO = 2'b11
    } rnd_e;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_FINITE,
        CLS_INF,
        CLS_NAN
    } cls_e;

    typedef struct packed {
        logic inv;
        logic ovf;
        logic unf;
        logic inx;
    } flags_t;

    typedef struct packed {
        logic             sign;
        logic [HP_EW-1:0] exp;
        logic [HP_MW-1:0] man;
    } half_t;

    typedef struct packed {
        logic             sign;
        logic [SP_EW-1:0] exp;
        logic [SP_MW-1:0] man;
    } single_t;

    function automatic logic round_inc(rnd_e m, logic neg, logic lsb,
                                       logic grd, logic stk);
        logic lost;
        lost = grd | stk;
        case (m)
            RND_NEAR: round_inc = grd & (stk | lsb);
            RND_POS:  round_inc = ~neg & lost;
            RND_NEG:  round_inc = neg & lost;
            default:  round_inc = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/f2h_special.sv
module f2h_special
    import f2h_pkg::*;
(
    input  single_t op,
    input  logic    alt_fmt,
    input  logic    dflt_nan,
    output cls_e    cls,
    output half_t   res,
    output flags_t  flg
);
    logic exp_max, man_nz, quiet;

    assign exp_max = &op.exp;
    assign man_nz  = |op.man;
    assign quiet   = op.man[SP_MW-1];

    always_comb begin
        if (exp_max && man_nz)       cls = CLS_NAN;
        else if (exp_max)            cls = CLS_INF;
        else if (op.exp == '0 && !man_nz) cls = CLS_ZERO;
        else                         cls = CLS_FINITE;
    end

    always_comb begin
        res = '0;
        flg = '0;
        unique case (cls)
            CLS_NAN: begin
                if (alt_fmt) begin
                    res.sign = op.sign;
                    flg.inv  = 1'b1;
                end else if (dflt_nan) begin
                    res.exp           = HP_EW'(HP_EMAX);
                    res.man[HP_MW-1]  = 1'b1;
                    flg.inv           = ~quiet;
                end else begin
                    res.sign          = op.sign;
                    res.exp           = HP_EW'(HP_EMAX);
                    res.man           = op.man[SP_MW-1 -: HP_MW];
                    res.man[HP_MW-1]  = 1'b1;
                    flg.inv           = ~quiet;
                end
            end
            CLS_INF: begin
                res.sign = op.sign;
                res.exp  = HP_EW'(HP_EMAX);
                if (alt_fmt) begin
                    res.man = '1;
                    flg.inv = 1'b1;
                end
            end
            CLS_ZERO: res.sign = op.sign;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/f2h_finite.sv
module f2h_finite
    import f2h_pkg::*;
(
    input  single_t op,
    input  rnd_e    rmode,
    input  logic    alt_fmt,
    input  logic    uf_trap_en,
    output half_t   res,
    output flags_t  flg
);
    localparam int WIDE_W = SIG_W + PAD;
    localparam int SH_W   = $clog2(PAD + 1);

    logic [SP_EW-1:0]        e_eff;
    logic [SIG_W-1:0]        sig;
    logic signed [EXP_W-1:0] he;
    logic                    tiny;
    logic [EXP_W-1:0]        sh_raw;
    logic [SH_W-1:0]         sh;
    logic [WIDE_W-1:0]       wide;
    logic [HP_MW:0]          kept;
    logic                    grd, stk, inexact, inc;
    logic [HP_MW+1:0]        sum;
    logic                    carry;
    logic [EXP_W-1:0]        re, er;
    logic                    to_inf;

    assign e_eff = (op.exp == '0) ? SP_EW'(1) : op.exp;
    assign sig   = {op.exp != '0, op.man};
    assign he    = $signed({2'b00, e_eff}) - EXP_W'(REBIAS);
    assign tiny  = (he <= 0);

    // extra right shift for subnormal results, clamped so all bits reach sticky
    assign sh_raw = EXP_W'(DROP + 1) - EXP_W'(he);
    assign sh     = !tiny ? SH_W'(DROP)
                  : (sh_raw > EXP_W'(PAD)) ? SH_W'(PAD) : SH_W'(sh_raw);

    assign wide = {sig, {PAD{1'b0}}} >> sh;
    assign kept = wide[PAD +: HP_MW+1];
    assign grd  = wide[PAD-1];
    assign stk  = |wide[PAD-2:0];

    assign inexact = grd | stk;
    assign inc     = round_inc(rmode, op.sign, kept[0], grd, stk);
    assign sum     = {1'b0, kept} + (HP_MW+2)'(inc);
    assign carry   = tiny ? sum[HP_MW] : sum[HP_MW+1];
    assign re      = tiny ? '0 : EXP_W'(he);
    assign er      = re + EXP_W'(carry);

    assign to_inf = (rmode == RND_NEAR) || (rmode == RND_POS && !op.sign)
                 || (rmode == RND_NEG && op.sign);

    always_comb begin
        res      = '0;
        res.sign = op.sign;
        res.exp  = er[HP_EW-1:0];
        res.man  = sum[HP_MW-1:0];
        flg      = '0;
        flg.inx  = inexact;
        flg.unf  = (re == '0) && (inexact || uf_trap_en);
        if (alt_fmt) begin
            if (er > EXP_W'(HP_EMAX)) begin
                res.exp = HP_EW'(HP_EMAX);
                res.man = '1;
                flg.inv = 1'b1;
                flg.inx = 1'b0;
            end
        end else if (er >= EXP_W'(HP_EMAX)) begin
            flg.ovf = 1'b1;
            flg.inx = 1'b1;
            if (to_inf) begin
                res.exp = HP_EW'(HP_EMAX);
                res.man = '0;
            end else begin
                res.exp = HP_EW'(HP_EMAX - 1);
                res.man = '1;
            end
        end
    end
endmodule

// File: rtl/f2h_insert.sv
module f2h_insert
    import f2h_pkg::*;
#(
    parameter int WORD_W = 2 * HP_W
) (
    input  logic [WORD_W-1:0] dst,
    input  half_t             half,
    input  logic              sel_hi,
    output logic [WORD_W-1:0] word
);
    localparam int LANES = WORD_W / HP_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic pick;
        assign pick = (g == LANES - 1) ? sel_hi : !sel_hi;
        assign word[g*HP_W +: HP_W] = pick ? half : dst[g*HP_W +: HP_W];
    end
endmodule

// File: rtl/f2h_convert.sv
module f2h_convert
    import f2h_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_vld,
    input  logic [31:0] src,
    input  logic [31:0] dst,
    input  logic        sel_hi,
    input  logic [1:0]  rmode,
    input  logic        dflt_nan,
    input  logic        alt_fmt,
    input  logic        uf_trap_en,
    output logic        out_vld,
    output logic [31:0] result,
    output logic        flg_invalid,
    output logic        flg_overflow,
    output logic        flg_underflow,
    output logic        flg_inexact
);
    single_t op;
    cls_e    cls;
    half_t   sp_res, fn_res, half;
    flags_t  sp_flg, fn_flg, flg, flg_q;
    logic [31:0] word;

    assign op = single_t'(src);

    f2h_special u_special (
        .op(op), .alt_fmt(alt_fmt), .dflt_nan(dflt_nan),
        .cls(cls), .res(sp_res), .flg(sp_flg)
    );

    f2h_finite u_finite (
        .op(op), .rmode(rnd_e'(rmode)), .alt_fmt(alt_fmt),
        .uf_trap_en(uf_trap_en), .res(fn_res), .flg(fn_flg)
    );

    assign half = (cls == CLS_FINITE) ? fn_res : sp_res;
    assign flg  = (cls == CLS_FINITE) ? fn_flg : sp_flg;

    f2h_insert #(.WORD_W(32)) u_insert (
        .dst(dst), .half(half), .sel_hi(sel_hi), .word(word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            result  <= '0;
            flg_q   <= '0;
        end else begin
            out_vld <= in_vld;
            flg_q   <= in_vld ? flg : '0;
            if (in_vld) result <= word;
        end
    end

    assign flg_invalid   = flg_q.inv;
    assign flg_overflow  = flg_q.ovf;
    assign flg_underflow = flg_q.unf;
    assign flg_inexact   = flg_q.inx;
endmodule

// File: rtl/f2h_convert_chk.sv
module f2h_convert_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_vld,
    input logic [31:0] src,
    input logic [31:0] dst,
    input logic        sel_hi,
    input logic        dflt_nan,
    input logic        alt_fmt,
    input logic        out_vld,
    input logic [31:0] result,
    input logic        flg_invalid,
    input logic        flg_overflow,
    input logic        flg_underflow,
    input logic        flg_inexact
);
    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R1
    vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld && $stable(result));
    // R1
    idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> !(flg_invalid || flg_overflow || flg_underflow || flg_inexact));
    // R2
    keep_lo_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld && sel_hi |=> result[15:0] == $past(dst[15:0]));
    // R2
    keep_hi_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld && !sel_hi |=> result[31:16] == $past(dst[31:16]));
    // R4
    dnan_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld && !sel_hi && !alt_fmt && dflt_nan && (&src[30:23]) && (|src[22:0])
        |=> result[15:0] == 16'h7E00);
    // R11
    ovf_inx_chk: assert property (@(posedge clk) disable iff (rst)
        flg_overflow |-> flg_inexact);
    // R12
    inv_alone_chk: assert property (@(posedge clk) disable iff (rst)
        flg_invalid |-> !flg_inexact && !flg_overflow);
endmodule

bind f2h_convert f2h_convert_chk u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .src(src), .dst(dst),
    .sel_hi(sel_hi), .dflt_nan(dflt_nan), .alt_fmt(alt_fmt),
    .out_vld(out_vld), .result(result), .flg_invalid(flg_invalid),
    .flg_overflow(flg_overflow), .flg_underflow(flg_underflow),
    .flg_inexact(flg_inexact)
);

// File: tb/test_f2h_convert.sv
module test_f2h_convert;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FILL = 32'hA5A5_A5A5;
    // {req[4], src[32], rmode[2], alt, dn, ufe, half[16], flags{inv,ovf,unf,inx}}
    localparam int NV = 39;
    localparam logic [60:0] VEC [NV] = '{
        {4'd7,  32'h3F800000, 2'd0, 3'b000, 16'h3C00, 4'b0000}, // R7
        {4'd7,  32'hC0000000, 2'd0, 3'b000, 16'hC000, 4'b0000}, // R7
        {4'd7,  32'h477FE000, 2'd0, 3'b000, 16'h7BFF, 4'b0000}, // R7
        {4'd8,  32'h3F801000, 2'd0, 3'b000, 16'h3C00, 4'b0001}, // R8 tie even
        {4'd8,  32'h3F801000, 2'd1, 3'b000, 16'h3C01, 4'b0001}, // R8
        {4'd8,  32'h3F803000, 2'd0, 3'b000, 16'h3C02, 4'b0001}, // R8 tie odd
        {4'd8,  32'hBF800001, 2'd2, 3'b000, 16'hBC01, 4'b0001}, // R8
        {4'd8,  32'hBF800001, 2'd1, 3'b000, 16'hBC00, 4'b0001}, // R8
        {4'd8,  32'h3F87FFFF, 2'd3, 3'b000, 16'h3C3F, 4'b0001}, // R8
        {4'd8,  32'h3F87FFFF, 2'd0, 3'b000, 16'h3C40, 4'b0001}, // R8
        {4'd9,  32'h3FFFF000, 2'd0, 3'b000, 16'h4000, 4'b0001}, // R9
        {4'd9,  32'h387FF000, 2'd0, 3'b000, 16'h0400, 4'b0011}, // R9
        {4'd11, 32'h47800000, 2'd0, 3'b000, 16'h7C00, 4'b0101}, // R11
        {4'd11, 32'h47800000, 2'd3, 3'b000, 16'h7BFF, 4'b0101}, // R11
        {4'd11, 32'hC7800000, 2'd1, 3'b000, 16'hFBFF, 4'b0101}, // R11
        {4'd11, 32'hC7800000, 2'd2, 3'b000, 16'hFC00, 4'b0101}, // R11
        {4'd11, 32'h477FF000, 2'd0, 3'b000, 16'h7C00, 4'b0101}, // R11
        {4'd11, 32'h477FF000, 2'd3, 3'b000, 16'h7BFF, 4'b0001}, // R11
        {4'd12, 32'h47800000, 2'd0, 3'b100, 16'h7C00, 4'b0000}, // R12
        {4'd12, 32'h48000000, 2'd0, 3'b100, 16'h7FFF, 4'b1000}, // R12
        {4'd12, 32'hC8000000, 2'd3, 3'b100, 16'hFFFF, 4'b1000}, // R12
        {4'd10, 32'h38000000, 2'd0, 3'b000, 16'h0200, 4'b0000}, // R10
        {4'd10, 32'h38000000, 2'd0, 3'b001, 16'h0200, 4'b0010}, // R10
        {4'd10, 32'h33800000, 2'd0, 3'b000, 16'h0001, 4'b0000}, // R10
        {4'd10, 32'h33000000, 2'd0, 3'b000, 16'h0000, 4'b0011}, // R10
        {4'd10, 32'h33000000, 2'd1, 3'b000, 16'h0001, 4'b0011}, // R10
        {4'd10, 32'h00000001, 2'd0, 3'b000, 16'h0000, 4'b0011}, // R10
        {4'd10, 32'h80000001, 2'd2, 3'b000, 16'h8001, 4'b0011}, // R10
        {4'd3,  32'h7FC00001, 2'd0, 3'b000, 16'h7E00, 4'b0000}, // R3
        {4'd3,  32'h7F800001, 2'd0, 3'b000, 16'h7E00, 4'b1000}, // R3
        {4'd3,  32'hFFA00000, 2'd0, 3'b000, 16'hFF00, 4'b1000}, // R3
        {4'd4,  32'hFFC12345, 2'd0, 3'b010, 16'h7E00, 4'b0000}, // R4
        {4'd4,  32'h7F812345, 2'd0, 3'b010, 16'h7E00, 4'b1000}, // R4
        {4'd5,  32'hFFC00000, 2'd0, 3'b100, 16'h8000, 4'b1000}, // R5
        {4'd5,  32'h7F800000, 2'd0, 3'b100, 16'h7FFF, 4'b1000}, // R5
        {4'd5,  32'hFF800000, 2'd0, 3'b000, 16'hFC00, 4'b0000}, // R5
        {4'd5,  32'hFFC00000, 2'd0, 3'b110, 16'h8000, 4'b1000}, // R5
        {4'd6,  32'h80000000, 2'd0, 3'b001, 16'h8000, 4'b0000}, // R6
        {4'd6,  32'h00000000, 2'd1, 3'b000, 16'h0000, 4'b0000}  // R6
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld, sel_hi, dflt_nan, alt_fmt, uf_trap_en;
    logic [31:0] src, dst;
    logic [1:0]  rmode;
    logic        out_vld;
    logic [31:0] result;
    logic        flg_invalid, flg_overflow, flg_underflow, flg_inexact;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    f2h_convert i_f2h_convert (
        .clk(clk), .rst(rst), .in_vld(in_vld), .src(src), .dst(dst),
        .sel_hi(sel_hi), .rmode(rmode), .dflt_nan(dflt_nan), .alt_fmt(alt_fmt),
        .uf_trap_en(uf_trap_en), .out_vld(out_vld), .result(result),
        .flg_invalid(flg_invalid), .flg_overflow(flg_overflow),
        .flg_underflow(flg_underflow), .flg_inexact(flg_inexact)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] flags4();
        return {28'd0, flg_invalid, flg_overflow, flg_underflow, flg_inexact};
    endfunction

    task automatic convert(input logic [31:0] s, input logic [31:0] d, input logic hi,
                           input logic [1:0] rm, input logic alt, input logic dn,
                           input logic ufe);
        @(negedge clk);
        src = s; dst = d; sel_hi = hi; rmode = rm;
        alt_fmt = alt; dflt_nan = dn; uf_trap_en = ufe; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_vld = 1'b0; src = '0; dst = '0; sel_hi = 1'b0;
        rmode = 2'd0; dflt_nan = 1'b0; alt_fmt = 1'b0; uf_trap_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset out_vld", {31'd0, out_vld}, 32'd0);
        check("R1 reset result", result, 32'd0);
        check("R1 reset flags", flags4(), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [60:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[60:57], i);
            convert(v[56:25], FILL, 1'b0, v[24:23], v[22], v[21], v[20]);
            check({tag, " out_vld"}, {31'd0, out_vld}, 32'd1);
            check({tag, " result"}, result, {FILL[31:16], v[19:4]});
            check({tag, " flags"}, flags4(), {28'd0, v[3:0]});
        end

        // R2 upper-half insertion keeps lower half
        convert(32'h3F800000, 32'h1234_5678, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R2 upper insert", result, 32'h3C00_5678);
        // R2 lower-half insertion keeps upper half
        convert(32'hC7800000, 32'h1234_5678, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R2 lower insert", result, 32'h1234_FBFF);
        check("R2 lower flags", flags4(), 32'h5);

        // R1 idle: inputs change without in_vld; result holds, flags low
        @(negedge clk);
        src = 32'h7F800001; dst = 32'hFFFF_FFFF; sel_hi = 1'b1;
        @(negedge clk);
        check("R1 idle out_vld", {31'd0, out_vld}, 32'd0);
        check("R1 idle result", result, 32'h1234_FBFF);
        check("R1 idle flags", flags4(), 32'd0);

        // R1 reset clears a held result
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears", result, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule